// File: doc/BRIEF.md
# Hybrid DC Breaker Opening and Current-Limiting Sequencer

This block is the state controller of a hybrid DC breaker. It orders the commands to the load-branch commutation switch, the fast mechanical disconnector, the main-breaker semiconductor cells and the residual current breaker. It takes a trip order, a limiting order, local measurement flags and switch position feedback. It then steers the breaker along one of three paths: straight to fully open, into fault current limiting, or from limiting back to closed.

An opening always starts with the commutation steps. The load switch is opened first. Once the load current is below the residual level, the disconnector is opened. Once it reports fully open, the main cells are engaged. A trip sends the cells straight to full insertion, which is limiting with a zero current reference. A limiting request, or local bus undervoltage, instead hands the cells to the external modulator. Limiting ends at full open when the trip order arrives, when cell energy is too high, or when the time budget runs out. It ends back at closed when every cell is bypassed again and reclosing is allowed. Every wait for feedback is bounded. A missed deadline marks a fault and drives the breaker open.

Top module: `hybrid_brk_seq`

## Requirements
- R1: During and after reset, with no request, all commands are at their closed values (`lsw_open`, `disc_open_cmd`, `cells_insert`, `limit_en`, `rcb_open` all 0) and `status` is 0 (closed). Status codes: 0 closed, 1 moving, 2 limiting, 3 open, 4 fault.
- R2: From closed, `trip_n`=0, `limit_n`=0 or `bus_uv`=1 (with the disconnector not reported open) sets `lsw_open` on the next clock and `status` to 1. Commands are registered and change only on entry to a new state.
- R3: `disc_open_cmd` is raised only after `load_i_low` is seen while the load switch is open. The cells act only after `disc_open_fb` is seen. A trip seen at any time during the commutation steps, even a one-cycle pulse, leads to full insertion rather than limiting.
- R4: If `disc_open_fb` is 1 when a request arrives in closed, the load-switch and disconnector steps are skipped. A trip goes straight to insertion and a limiting request goes straight to limiting.
- R5: In limiting (`limit_en`=1, `status`=2), any of the following moves the breaker to insertion on the next clock: `trip_n`=0, `cell_energy_hi`=1, or limiting having lasted `lim_cycles` cycles (a value of 0 acts as 1).
- R6: In limiting, `cells_all_bypassed`=1 with `reclose_inhibit`=0 closes the disconnector command. After `disc_closed_fb`, the load switch is closed and status returns to 0. With `reclose_inhibit`=1 the bypass flag is ignored.
- R7: On insertion `cells_insert` is 1. `rcb_open` follows once `line_i_low` is seen, and status becomes 3. The open state then holds until reset, whatever the inputs do.
- R8: A state that waits for feedback (load current low, disconnector open, disconnector closed, line current low) and gets none for `WAIT_TMO` cycles sets `status` to 4 until reset and forces the open path.
- R9: If an exit to open and reclose permission occur in the same cycle, the exit to open wins. If the awaited feedback arrives in the last cycle of a wait, the feedback wins and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_n | input | 1 | Trip order, active low |
| limit_n | input | 1 | Limiting order, active low |
| bus_uv | input | 1 | Local bus undervoltage flag |
| load_i_low | input | 1 | Load-branch current below residual level |
| line_i_low | input | 1 | Line current below residual level |
| disc_open_fb | input | 1 | Disconnector fully open |
| disc_closed_fb | input | 1 | Disconnector fully closed |
| cell_energy_hi | input | 1 | Some cell arrester over its energy limit |
| cells_all_bypassed | input | 1 | Every main cell bypassed (fault cleared) |
| reclose_inhibit | input | 1 | Forbid the return to closed |
| lim_cycles | input | CNT_W | Limiting time budget in clock cycles |
| lsw_open | output | 1 | Open command for the load switch |
| disc_open_cmd | output | 1 | Open command for the disconnector |
| cells_insert | output | 1 | Force all main cells inserted |
| limit_en | output | 1 | Hand the main cells to the limiting modulator |
| rcb_open | output | 1 | Open command for the residual breaker |
| status | output | 3 | 0 closed, 1 moving, 2 limiting, 3 open, 4 fault |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a reason to leave limiting for open together with the bypass-and-reclose condition. The bench raises `cells_all_bypassed` and `cell_energy_hi` on the same clock, and a reference model requires insertion, not a disconnector close. The second pair is feedback arriving on the last cycle of a wait timeout. The bench places `load_i_low` on exactly that cycle and requires status 1 (moving) rather than 4 (fault), with the disconnector command following.

// File: rtl/hybrid_brk_seq.sv
module hybrid_brk_seq #(
  parameter int CNT_W    = 16,
  parameter int WAIT_TMO = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_n,
  input  logic             limit_n,
  input  logic             bus_uv,
  input  logic             load_i_low,
  input  logic             line_i_low,
  input  logic             disc_open_fb,
  input  logic             disc_closed_fb,
  input  logic             cell_energy_hi,
  input  logic             cells_all_bypassed,
  input  logic             reclose_inhibit,
  input  logic [CNT_W-1:0] lim_cycles,
  output logic             lsw_open,
  output logic             disc_open_cmd,
  output logic             cells_insert,
  output logic             limit_en,
  output logic             rcb_open,
  output logic [2:0]       status
);

  typedef enum logic [2:0] {
    S_CLOSED, S_LSW, S_DISC, S_LIMIT, S_INSERT, S_OPEN, S_RECLOSE
  } st_t;

  localparam logic [2:0] ST_CLOSED = 3'd0;
  localparam logic [2:0] ST_MOVING = 3'd1;
  localparam logic [2:0] ST_LIMIT  = 3'd2;
  localparam logic [2:0] ST_OPEN   = 3'd3;
  localparam logic [2:0] ST_FAULT  = 3'd4;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(WAIT_TMO - 1);
  localparam logic [CNT_W:0]   ONE      = (CNT_W+1)'(1);

  st_t              st, nx;
  logic [CNT_W-1:0] t;
  logic             full_q, flt_q, flt_nx;

  wire go_full   = full_q | ~trip_n;
  wire wait_over = (t >= TMO_LAST);
  wire lim_over  = (({1'b0, t} + ONE) >= {1'b0, lim_cycles});
  wire open_exit = ~trip_n | cell_energy_hi | lim_over;
  wire req_lim   = ~limit_n | bus_uv;

  always_comb begin
    nx     = st;
    flt_nx = flt_q;
    case (st)
      S_CLOSED:
        if (~trip_n)       nx = disc_open_fb ? S_INSERT : S_LSW;
        else if (req_lim)  nx = disc_open_fb ? S_LIMIT  : S_LSW;
      S_LSW:
        if (load_i_low)      nx = S_DISC;
        else if (wait_over) begin nx = S_INSERT; flt_nx = 1'b1; end
      S_DISC:
        if (disc_open_fb)    nx = go_full ? S_INSERT : S_LIMIT;
        else if (wait_over) begin nx = S_INSERT; flt_nx = 1'b1; end
      S_LIMIT:
        if (open_exit)       nx = S_INSERT;
        else if (cells_all_bypassed & ~reclose_inhibit) nx = S_RECLOSE;
      S_RECLOSE:
        if (~trip_n)         nx = S_INSERT;
        else if (disc_closed_fb) nx = S_CLOSED;
        else if (wait_over) begin nx = S_INSERT; flt_nx = 1'b1; end
      S_INSERT:
        if (line_i_low)      nx = S_OPEN;
        else if (wait_over) begin nx = S_OPEN; flt_nx = 1'b1; end
      S_OPEN: nx = S_OPEN;
      default: nx = S_INSERT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_CLOSED;
      t      <= '0;
      full_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      st     <= nx;
      flt_q  <= flt_nx;
      full_q <= (st == S_CLOSED) ? ~trip_n : go_full;
      if (nx != st)   t <= '0;
      else if (~&t)   t <= t + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsw_open      <= 1'b0;
      disc_open_cmd <= 1'b0;
      cells_insert  <= 1'b0;
      limit_en      <= 1'b0;
      rcb_open      <= 1'b0;
      status        <= ST_CLOSED;
    end else begin
      lsw_open      <= (nx != S_CLOSED);
      disc_open_cmd <= (nx inside {S_DISC, S_LIMIT, S_INSERT, S_OPEN});
      cells_insert  <= (nx inside {S_INSERT, S_OPEN});
      limit_en      <= (nx == S_LIMIT);
      rcb_open      <= (nx == S_OPEN);
      if (flt_nx)                status <= ST_FAULT;
      else if (nx == S_CLOSED)   status <= ST_CLOSED;
      else if (nx == S_LIMIT)    status <= ST_LIMIT;
      else if (nx == S_OPEN)     status <= ST_OPEN;
      else                       status <= ST_MOVING;
    end
  end

  logic [CNT_W-1:0] lim_run;
  always_ff @(posedge clk) begin
    if (!rst_n || !limit_en) lim_run <= '0;
    else if (~&lim_run)      lim_run <= lim_run + 1'b1;
  end

  p_lsw_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSED && !trip_n && !disc_open_fb)
      |=> (lsw_open && !disc_open_cmd && status == ST_MOVING));

  p_disc_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disc_open_cmd) |-> ($past(load_i_low) || $past(disc_open_fb) || status == ST_FAULT));

  p_lim_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && (!trip_n || cell_energy_hi)) |=> (!limit_en && cells_insert));

  p_lim_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    limit_en |-> (lim_run < lim_cycles || lim_run == '0));

  p_lsw_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lsw_open) |-> $past(disc_closed_fb));

  p_rcb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcb_open) |-> ($past(line_i_low) || status == ST_FAULT));

  p_open_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rcb_open |=> rcb_open);

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_FAULT) |=> (status == ST_FAULT));

  p_exit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && cell_energy_hi && cells_all_bypassed) |=> (cells_insert && disc_open_cmd));

endmodule

// File: tb/test_hybrid_brk_seq.sv
`timescale 1ns/1ps
module test_hybrid_brk_seq;
  localparam int CW  = 16;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rst_n, trip_n, limit_n, bus_uv, load_i_low, line_i_low;
  logic disc_open_fb, disc_closed_fb, cell_energy_hi, cells_all_bypassed, reclose_inhibit;
  logic [CW-1:0] lim;
  logic lsw_open, disc_open_cmd, cells_insert, limit_en, rcb_open;
  logic [2:0] status;

  always #2 clk = ~clk;

  hybrid_brk_seq #(.CNT_W(CW), .WAIT_TMO(TMO)) i_hybrid_brk_seq (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .limit_n(limit_n), .bus_uv(bus_uv),
    .load_i_low(load_i_low), .line_i_low(line_i_low), .disc_open_fb(disc_open_fb),
    .disc_closed_fb(disc_closed_fb), .cell_energy_hi(cell_energy_hi),
    .cells_all_bypassed(cells_all_bypassed), .reclose_inhibit(reclose_inhibit),
    .lim_cycles(lim), .lsw_open(lsw_open), .disc_open_cmd(disc_open_cmd),
    .cells_insert(cells_insert), .limit_en(limit_en), .rcb_open(rcb_open), .status(status));

  // reference model: phase 0 closed,1 load sw,2 disc,3 limiting,4 inserting,5 open,6 reclosing
  int ph, np, tm;
  bit full, flt, gf, tmo, limx;
  int e_lsw, e_disc, e_ins, e_lim, e_rcb, e_st;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; full = 0; flt = 0; tm = 0;
    end else begin
      np   = ph;
      gf   = full || !trip_n;
      tmo  = (tm >= TMO - 1);
      limx = (tm + 1 >= int'(lim));
      if (ph == 0) begin
        if (!trip_n) np = disc_open_fb ? 4 : 1;
        else if (!limit_n || bus_uv) np = disc_open_fb ? 3 : 1;
      end else if (ph == 1) begin
        if (load_i_low) np = 2; else if (tmo) begin np = 4; flt = 1; end
      end else if (ph == 2) begin
        if (disc_open_fb) np = gf ? 4 : 3; else if (tmo) begin np = 4; flt = 1; end
      end else if (ph == 3) begin
        if (!trip_n || cell_energy_hi || limx) np = 4;
        else if (cells_all_bypassed && !reclose_inhibit) np = 6;
      end else if (ph == 6) begin
        if (!trip_n) np = 4; else if (disc_closed_fb) np = 0;
        else if (tmo) begin np = 4; flt = 1; end
      end else if (ph == 4) begin
        if (line_i_low) np = 5; else if (tmo) begin np = 5; flt = 1; end
      end
      full = (ph == 0) ? !trip_n : gf;
      tm   = (np == ph) ? tm + 1 : 0;
      ph   = np;
    end
    e_lsw  = (ph != 0);
    e_disc = (ph == 2 || ph == 3 || ph == 4 || ph == 5);
    e_ins  = (ph == 4 || ph == 5);
    e_lim  = (ph == 3);
    e_rcb  = (ph == 5);
    e_st   = flt ? 4 : (ph == 0) ? 0 : (ph == 3) ? 2 : (ph == 5) ? 3 : 1;
  end

  int vecs = 0, miss = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic cmp(string nm, int act, int exp);
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      vecs++;
      cmp("lsw_open", lsw_open, e_lsw);
      cmp("disc_open_cmd", disc_open_cmd, e_disc);
      cmp("cells_insert", cells_insert, e_ins);
      cmp("limit_en", limit_en, e_lim);
      cmp("rcb_open", rcb_open, e_rcb);
      cmp("status", status, e_st);
    end
  endtask

  task automatic idle_in();
    trip_n = 1; limit_n = 1; bus_uv = 0; load_i_low = 0; line_i_low = 0;
    disc_open_fb = 0; disc_closed_fb = 1; cell_energy_hi = 0;
    cells_all_bypassed = 0; reclose_inhibit = 0; lim = 20;
  endtask

  task automatic do_reset();
    rst_n = 0; idle_in(); cyc(3); rst_n = 1; cyc(2);
  endtask

  task automatic disc_to_open();
    disc_closed_fb = 0; disc_open_fb = 1;
  endtask

  initial begin
    rst_n = 0; idle_in();
    cur_req = "R1"; do_reset(); cyc(3);

    // trip path with a one-cycle trip pulse
    cur_req = "R2"; trip_n = 0; cyc(1); trip_n = 1; cyc(4);
    cur_req = "R3"; load_i_low = 1; cyc(1); load_i_low = 0; cyc(3);
    disc_to_open(); cyc(2);
    cur_req = "R7"; cyc(3); line_i_low = 1; cyc(2); line_i_low = 0;
    limit_n = 0; cells_all_bypassed = 1; trip_n = 0; cyc(5);

    // limiting then return to closed
    do_reset();
    cur_req = "R2"; limit_n = 0; cyc(1);
    cur_req = "R6"; load_i_low = 1; cyc(2); disc_to_open(); cyc(3);
    limit_n = 1; cells_all_bypassed = 1; cyc(1); cells_all_bypassed = 0;
    disc_open_fb = 0; cyc(2); disc_closed_fb = 1; cyc(3);

    // undervoltage entry, energy exit
    do_reset();
    cur_req = "R5"; bus_uv = 1; load_i_low = 1; cyc(2); bus_uv = 0; disc_to_open(); cyc(3);
    cell_energy_hi = 1; cyc(1); cell_energy_hi = 0; cyc(3); line_i_low = 1; cyc(3);

    // skip path into limiting, time budget exit
    do_reset();
    cur_req = "R4"; lim = 10; disc_to_open(); limit_n = 0; cyc(1); limit_n = 1;
    cur_req = "R5"; cyc(14);

    // skip path with trip
    do_reset();
    cur_req = "R4"; disc_to_open(); trip_n = 0; cyc(1); trip_n = 1; cyc(2);

    // reclose inhibited
    do_reset();
    cur_req = "R6"; lim = 12; disc_to_open(); reclose_inhibit = 1; limit_n = 0; cyc(1);
    limit_n = 1; cells_all_bypassed = 1; cyc(15);

    // wait timeout
    do_reset();
    cur_req = "R8"; limit_n = 0; cyc(1); limit_n = 1; cyc(15); line_i_low = 1; cyc(3);

    // coincidence: energy exit and bypass in one cycle
    do_reset();
    cur_req = "R9"; lim = 40; disc_to_open(); limit_n = 0; cyc(1);
    cells_all_bypassed = 1; cell_energy_hi = 1; cyc(3);

    // coincidence: feedback on the last wait cycle
    do_reset();
    cur_req = "R9"; trip_n = 0; cyc(1); trip_n = 1; cyc(TMO - 1);
    load_i_low = 1; cyc(1); load_i_low = 0; cyc(2);

    // trip while limiting
    do_reset();
    cur_req = "R5"; disc_to_open(); limit_n = 0; cyc(1); trip_n = 0; cyc(1); trip_n = 1; cyc(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule